// File: doc/BRIEF.md
# Serial Register Port for a Scanner Front-End

This block is the slave end of a three-wire control link for a colour scanner front-end. A host drives a serial clock, a frame-select line and a data line. Through that link the host can write or read back a bank of eight 9-bit control words:

- one operating-mode word;
- one channel-sequencing word;
- three gain words, one per colour;
- three offset words, one per colour.

Every stored word is presented on parallel outputs, so the sampling, gain and offset logic elsewhere on the chip can use it directly.

The serial pins are oversampled by the block's own system clock. They pass through a synchronizer, and edges are found by comparing successive samples. This puts the whole register bank in a single clock domain. The line is bidirectional, but it is exposed as separate data-out and drive-enable outputs, and the pad driver sits outside the block.

A frame is 13 bits, sent most significant bit first, in this order:

- a direction flag: 0 = write, 1 = read;
- a 3-bit address;
- a 9-bit data field.

A write takes effect when the frame-select line drops, and only if exactly 13 bits were clocked in. In a read, the addressed word is shifted out after the address bits.

Top module: `cfgser_top`

## Requirements
- R1: After reset the words hold these values:
  - address 0 (mode word) = 0x038: bit 5 three-channel, bit 4 correlated sampling and bit 3 high clamp bias set; bit 2 power-down, bit 1 input range and the format bits clear;
  - address 1 (sequencing word) = 0x0C0: bit 7 red-first order and bit 6 red select set;
  - the gain and offset words = 0.
- R2: A frame is a direction flag followed by address bits A2..A0 and data bits D8..D0. Data is sampled on the rising serial-clock edge. A flag of 0 stores D8..D0 into the addressed word when the frame-select line deasserts.
  - Address map: 0 mode, 1 sequencing, 2/3/4 red/green/blue gain, 5/6/7 red/green/blue offset.
- R3: Gain words store only D5..D0 as a straight binary code. Bits 8..6 of a gain word always read and hold zero, whatever was written.
- R4: Offset words store all nine bits in sign-magnitude form, with bit 8 the sign and bits 7..0 the magnitude.
- R5: A frame that contains any number of bits other than 13 changes no word.
- R6: Serial-clock edges while frame-select is low are ignored. They shift nothing and do not disturb the following frame.
- R7: When the flag is 1, the block drives the data line with D8..D0 of the addressed word after the falling serial-clock edges that follow the fourth and each later rising edge. A read changes no word.
- R8: The drive enable is low whenever frame-select is low, and it stays low throughout write frames.
- R9: The sleep output equals bit 2 of the mode word. All words keep their contents while sleep is high, and writes are still accepted then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock from the host |
| serLoad | input | 1 | Frame select, active high |
| serDin | input | 1 | Serial data from the host |
| serDout | output | 1 | Serial read data toward the pad |
| serDoutEn | output | 1 | Drive enable for the data pad |
| cfgWord | output | 9 | Operating-mode word |
| muxWord | output | 9 | Channel-sequencing word |
| gainRed | output | 9 | Red gain word |
| gainGreen | output | 9 | Green gain word |
| gainBlue | output | 9 | Blue gain word |
| offRed | output | 9 | Red offset word |
| offGreen | output | 9 | Green offset word |
| offBlue | output | 9 | Blue offset word |
| sleep | output | 1 | Power-down request |

## Verification
The bench builds the block with its default widths: a 3-bit address, a 9-bit word, a 6-bit gain code and a two-stage synchronizer. It drives the serial link with a half period of eight system clocks. With these values the bench can reach:

- every one of the eight addresses;
- both signs and the full magnitude of the offset words;
- gain writes that set the reserved bits;
- frames one bit short and one bit long;
- reads issued while sleep is high.

The host-side timing leaves room for the synchronizer and output-register latency before each read bit is sampled.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
  parameter int ADDR_W = 3;
  parameter int DATA_W = 9;
  parameter int GAIN_W = 6;

  localparam int NUM_REGS   = 1 << ADDR_W;
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  // word addresses
  localparam int A_CFG    = 0;
  localparam int A_MUX    = 1;
  localparam int A_GAIN_R = 2;
  localparam int A_GAIN_B = 4;
  localparam int A_OFF_R  = 5;
  localparam int A_OFF_B  = 7;

  // mode-word fields
  localparam int TRIPLE_BIT = 5;
  localparam int CDS_BIT    = 4;
  localparam int CLAMP_BIT  = 3;
  localparam int PDOWN_BIT  = 2;

  // sequencing-word fields
  localparam int ORDER_BIT = 7;
  localparam int REDSEL_BIT = 6;

  localparam logic [DATA_W-1:0] CFG_RESET =
    DATA_W'((1 << TRIPLE_BIT) | (1 << CDS_BIT) | (1 << CLAMP_BIT));
  localparam logic [DATA_W-1:0] MUX_RESET =
    DATA_W'((1 << ORDER_BIT) | (1 << REDSEL_BIT));
  localparam logic [DATA_W-1:0] GAIN_KEEP = DATA_W'((1 << GAIN_W) - 1);

  typedef struct packed {
    logic              commit;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic [ADDR_W-1:0] rdAddr;
  } bankCmd_t;
endpackage

// File: rtl/cfgser_ctrl.sv
module cfgser_ctrl
  import cfgser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serLoad,
  input  logic              serDin,
  input  logic [DATA_W-1:0] rdWord,
  output bankCmd_t          cmd,
  output logic              sdOut,
  output logic              sdOe
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);

  logic [SYNC_STAGES-1:0][2:0] syncQ;
  logic loadS, clkS, dinS;
  logic clkPrev, loadPrev;
  logic rise, fall, loadEnd;
  logic [FRAME_BITS-1:0] shiftQ;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] bitIdx;
  logic rdFlag;
  logic [ADDR_W-1:0] rdAddrQ;

  // pin synchronizer, all three pins move through the same stages
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= {serLoad, serClk, serDin};
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign {loadS, clkS, dinS} = syncQ[SYNC_STAGES-1];
  assign rise    = clkS & ~clkPrev;
  assign fall    = ~clkS & clkPrev;
  assign loadEnd = loadPrev & ~loadS;
  assign bitIdx  = CNT_FULL - CNT_W'(1) - bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
      shiftQ   <= '0;
      bitCnt   <= '0;
      rdFlag   <= 1'b0;
      rdAddrQ  <= '0;
      sdOut    <= 1'b0;
      sdOe     <= 1'b0;
    end else begin
      clkPrev  <= clkS;
      loadPrev <= loadS;
      if (!loadS) begin
        bitCnt <= '0;
        rdFlag <= 1'b0;
        sdOe   <= 1'b0;
      end else begin
        if (rise) begin
          shiftQ <= {shiftQ[FRAME_BITS-2:0], dinS};
          if (bitCnt != CNT_CAP) bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CNT_ADDR) begin
            rdFlag  <= shiftQ[ADDR_W-1];
            rdAddrQ <= {shiftQ[ADDR_W-2:0], dinS};
          end
        end
        if (fall && rdFlag && bitCnt >= CNT_HDR && bitCnt < CNT_FULL) begin
          sdOe  <= 1'b1;
          sdOut <= rdWord[bitIdx[IDX_W-1:0]];
        end
      end
    end
  end

  always_comb begin
    cmd.commit = loadEnd && (bitCnt == CNT_FULL) && !shiftQ[FRAME_BITS-1];
    cmd.wrAddr = shiftQ[DATA_W +: ADDR_W];
    cmd.wrData = shiftQ[DATA_W-1:0];
    cmd.rdAddr = rdAddrQ;
  end

  // R8
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadS |=> !sdOe);
  // R6
  idle_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadS && rise) |=> $stable(shiftQ));
  // R5
  commit_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |-> (!loadS && $past(loadS)));
  // R7
  read_only_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdOe) |-> ($past(rdFlag) && $past(loadS)));
endmodule

// File: rtl/cfgser_bank.sv
module cfgser_bank
  import cfgser_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  bankCmd_t                         cmd,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regsOut,
  output logic [DATA_W-1:0]                rdWord
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regsQ;

  function automatic logic [DATA_W-1:0] resetVal(int a);
    if (a == A_CFG) return CFG_RESET;
    if (a == A_MUX) return MUX_RESET;
    return '0;
  endfunction

  function automatic logic [DATA_W-1:0] keepMask(int a);
    if (a >= A_GAIN_R && a <= A_GAIN_B) return GAIN_KEEP;
    return '1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < NUM_REGS; a++) regsQ[a] <= resetVal(a);
    end else if (cmd.commit) begin
      regsQ[cmd.wrAddr] <= cmd.wrData & keepMask(int'(cmd.wrAddr));
    end
  end

  assign regsOut = regsQ;
  assign rdWord  = regsQ[cmd.rdAddr];

  // R3
  gain_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commit && cmd.wrAddr >= ADDR_W'(A_GAIN_R) && cmd.wrAddr <= ADDR_W'(A_GAIN_B))
    |=> (regsQ[$past(cmd.wrAddr)][DATA_W-1:GAIN_W] == '0 &&
         regsQ[$past(cmd.wrAddr)][GAIN_W-1:0] == $past(cmd.wrData[GAIN_W-1:0])));
  // R4
  offset_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commit && cmd.wrAddr >= ADDR_W'(A_OFF_R))
    |=> regsQ[$past(cmd.wrAddr)] == $past(cmd.wrData));
  // R5
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.commit |=> $stable(regsQ));
endmodule

// File: rtl/cfgser_top.sv
module cfgser_top
  import cfgser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serLoad,
  input  logic              serDin,
  output logic              serDout,
  output logic              serDoutEn,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] muxWord,
  output logic [DATA_W-1:0] gainRed,
  output logic [DATA_W-1:0] gainGreen,
  output logic [DATA_W-1:0] gainBlue,
  output logic [DATA_W-1:0] offRed,
  output logic [DATA_W-1:0] offGreen,
  output logic [DATA_W-1:0] offBlue,
  output logic              sleep
);
  bankCmd_t cmd;
  logic [DATA_W-1:0] rdWord;
  logic [NUM_REGS-1:0][DATA_W-1:0] regsOut;

  cfgser_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLoad(serLoad), .serDin(serDin),
    .rdWord(rdWord), .cmd(cmd), .sdOut(serDout), .sdOe(serDoutEn)
  );

  cfgser_bank u_bank (
    .clk(clk), .rstN(rstN), .cmd(cmd), .regsOut(regsOut), .rdWord(rdWord)
  );

  assign cfgWord   = regsOut[A_CFG];
  assign muxWord   = regsOut[A_MUX];
  assign gainRed   = regsOut[A_GAIN_R];
  assign gainGreen = regsOut[A_GAIN_R+1];
  assign gainBlue  = regsOut[A_GAIN_B];
  assign offRed    = regsOut[A_OFF_R];
  assign offGreen  = regsOut[A_OFF_R+1];
  assign offBlue   = regsOut[A_OFF_B];
  assign sleep     = cfgWord[PDOWN_BIT];
endmodule

// File: tb/cfgser_top_tb.sv
module cfgser_top_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic serClk = 1'b0, serLoad = 1'b0, serDin = 1'b0;
  logic serDout, serDoutEn, sleep;
  logic [8:0] cfgWord, muxWord, gainRed, gainGreen, gainBlue, offRed, offGreen, offBlue;

  int checks = 0, errors = 0;
  bit cmpOn = 0;
  logic [8:0] model [8];

  cfgser_top u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLoad(serLoad), .serDin(serDin),
    .serDout(serDout), .serDoutEn(serDoutEn), .cfgWord(cfgWord), .muxWord(muxWord),
    .gainRed(gainRed), .gainGreen(gainGreen), .gainBlue(gainBlue),
    .offRed(offRed), .offGreen(offGreen), .offBlue(offBlue), .sleep(sleep)
  );

  always #5 clk = ~clk;

  function automatic logic [8:0] outOf(int a);
    case (a)
      0: return cfgWord;   1: return muxWord;
      2: return gainRed;   3: return gainGreen;  4: return gainBlue;
      5: return offRed;    6: return offGreen;   default: return offBlue;
    endcase
  endfunction

  function automatic string tagOf(int a);
    if (a >= 2 && a <= 4) return "R3";
    if (a >= 5) return "R4";
    return "R2";
  endfunction

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model compared on every clock
  always @(negedge clk) begin
    if (cmpOn) begin
      for (int a = 0; a < 8; a++) begin
        checks++;
        if (outOf(a) !== model[a]) begin
          errors++;
          $display("FAIL %s word %0d actual %0h expected %0h", tagOf(a), a, outOf(a), model[a]);
        end
      end
      checks++;
      if (sleep !== model[0][2]) begin
        errors++;
        $display("FAIL R9 sleep actual %0b expected %0b", sleep, model[0][2]);
      end
    end
  end

  task automatic xfer(input logic [15:0] pat, input int n, output logic [8:0] rd, output int oeHits);
    rd = '0;
    oeHits = 0;
    @(negedge clk);
    serLoad = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      serDin = pat[n-1-i];
      repeat (HALF) @(negedge clk);
      if (i >= 4 && i < 13) begin
        rd[12-i] = serDout;
        if (serDoutEn) oeHits++;
      end
      serClk = 1'b1;
      repeat (HALF) @(negedge clk);
      serClk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    serLoad = 1'b0;
    serDin = 1'b0;
    if (n == 13 && !pat[12]) begin
      repeat (3) @(posedge clk);
      #1;
      if (pat[11:9] >= 2 && pat[11:9] <= 4) model[pat[11:9]] = {3'b000, pat[5:0]};
      else model[pat[11:9]] = pat[8:0];
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] addr, input logic [8:0] data);
    logic [8:0] rd;
    int oe;
    xfer({3'b000, 1'b0, addr, data}, 13, rd, oe);
    expect_eq("R8 drive enable during write", oe, 0);
  endtask

  task automatic rdChk(input logic [2:0] addr, input string tag);
    logic [8:0] rd;
    int oe;
    xfer({3'b000, 1'b1, addr, 9'h000}, 13, rd, oe);
    expect_eq("R7 read drive enable count", oe, 9);
    expect_eq(tag, int'(rd), int'(model[addr]));
  endtask

  initial begin
    model[0] = 9'h038; model[1] = 9'h0C0;
    for (int a = 2; a < 8; a++) model[a] = 9'h000;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_eq("R1 mode word", cfgWord, 9'h038);
    expect_eq("R1 sequencing word", muxWord, 9'h0C0);
    expect_eq("R1 red gain", gainRed, 0);
    expect_eq("R1 green gain", gainGreen, 0);
    expect_eq("R1 blue gain", gainBlue, 0);
    expect_eq("R1 red offset", offRed, 0);
    expect_eq("R1 blue offset", offBlue, 0);
    expect_eq("R1 sleep", sleep, 0);
    expect_eq("R8 idle drive enable", serDoutEn, 0);
    cmpOn = 1;

    rdChk(3'd0, "R7 read mode word");
    rdChk(3'd1, "R7 read sequencing word");

    // R3 gain words drop bits 8..6
    wr(3'd3, 9'h1FF);
    expect_eq("R3 green gain masked", gainGreen, 9'h03F);
    wr(3'd2, 9'h0AA);
    wr(3'd4, 9'h140);
    expect_eq("R3 blue gain all reserved", gainBlue, 0);
    rdChk(3'd3, "R3 read green gain");

    // R4 sign-magnitude offsets, all nine bits
    wr(3'd5, 9'h1FF);
    wr(3'd6, 9'h080);
    wr(3'd7, 9'h17F);
    expect_eq("R4 red offset", offRed, 9'h1FF);
    rdChk(3'd5, "R4 read red offset");
    rdChk(3'd7, "R4 read blue offset");

    // R2 sequencing word
    wr(3'd1, 9'h1AA);
    rdChk(3'd1, "R2 read sequencing word");
    rdChk(3'd2, "R2 read red gain");

    // R5 short and long frames
    begin
      logic [8:0] rd;
      int oe;
      xfer(16'h0A55, 12, rd, oe);
      rdChk(3'd5, "R5 short frame ignored");
      xfer(16'h0B33, 14, rd, oe);
      rdChk(3'd6, "R5 long frame ignored");
    end

    // R6 clock edges with frame select low
    for (int i = 0; i < 20; i++) begin
      serDin = i[0];
      serClk = 1'b1;
      repeat (HALF) @(negedge clk);
      expect_eq("R8 enable low while deselected", serDoutEn, 0);
      serClk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    serDin = 1'b0;
    wr(3'd7, 9'h011);
    expect_eq("R6 frame after idle edges", offBlue, 9'h011);
    rdChk(3'd7, "R6 read after idle edges");

    // R9 power-down keeps words and accepts writes
    wr(3'd0, 9'h03C);
    expect_eq("R9 sleep set", sleep, 1);
    wr(3'd3, 9'h025);
    rdChk(3'd3, "R9 write during sleep");
    rdChk(3'd6, "R9 word kept during sleep");
    wr(3'd0, 9'h038);
    expect_eq("R9 sleep cleared", sleep, 0);

    cmpOn = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule